// File: doc/BRIEF.md
# Bus Transceiver Power-State Sequencer

This block decides which of four operating states a low-speed vehicle bus transceiver is in (protected start-up, active, quiet and deep-power-down) and derives from that state the enables for the supply regulator, the external high-side load switch, the supervision timer, and the transmit and receive paths. A host moves the transceiver between states with two pins only. Raising the enable pin makes the bus usable. Dropping it parks the transceiver in a low-power state. The level on the transmit-data line at the moment enable drops selects which low-power state that is.

When enable falls, the transmit-data line is watched over a short acceptance window. This lets a host that releases both lines at nearly the same moment still reach deep power-down. Two independent wake filters bring the block out of either low-power state. The local wake pin is active low. The ignition pin reacts to a rising edge, and the two use different hold times. A wake always goes through the protected start-up state, so the regulator can ramp and the system reset can clear before the bus is enabled again. Inputs are expected to be synchronous to the block clock already.

Top module: `xcvr_mode_ctrl`

## Requirements
- R1: With the reset indication low and enable high, the block moves from protected start-up to active on the next clock edge. It stays active while enable remains high. While active, all five enables are on and `mode_o` reads 1.
- R2: When enable falls while active and transmit data is high on every one of the SEL_WIN_CYC samples that start with the first low enable sample, the block enters quiet mode (`mode_o` = 2) after the last of those samples. In quiet mode only the regulator enable is on.
- R3: When enable falls while active and transmit data is low on any sample inside that window (including the first), the block enters deep power-down (`mode_o` = 3) on that edge. A simultaneous fall of both pins also selects deep power-down. In deep power-down every enable is off.
- R4: A high reset indication while active or quiet forces protected start-up (`mode_o` = 0) on the next edge, and takes priority over a pending low-power selection. In protected start-up the regulator, load switch and supervision enables are on, and transmit and receive are off. The block leaves protected start-up only when the indication is low and enable is high.
- R5: The reset indication has no effect in deep power-down.
- R6: If enable returns high before the window has closed, the selection is abandoned and the block remains active.
- R7: In quiet or deep power-down mode, a high-to-low transition on the local wake pin followed by LOCAL_DB_CYC consecutive low samples (counting the first) moves the block to protected start-up.
- R8: In quiet or deep power-down mode, a low-to-high transition on the ignition pin followed by IGN_DB_CYC consecutive high samples moves the block to protected start-up.
- R9: A wake pin that is already at its active level when a low-power state is entered does not wake the block. A wake pulse shorter than its hold time does not wake the block either.
- R10: Enable is ignored in deep power-down. In quiet mode, a high enable with no reset indication and no wake returns the block to active on the next edge.
- R11: A low synchronous `rst_n` puts the block in protected start-up. The state code on `mode_o` is 0 protected start-up, 1 active, 2 quiet, 3 deep power-down.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Synchronous reset, active low |
| en_i | input | 1 | Host enable pin level |
| txd_i | input | 1 | Transmit-data line level |
| wake_n_i | input | 1 | Local wake pin, active low |
| ign_i | input | 1 | Ignition wake pin, rising-edge sensitive |
| rst_ind_i | input | 1 | System reset indication, high while reset is active |
| reg_en_o | output | 1 | Supply regulator enable |
| inh_en_o | output | 1 | External high-side load switch enable |
| wdg_en_o | output | 1 | Supervision timer enable |
| tx_en_o | output | 1 | Transmit path enable |
| rx_en_o | output | 1 | Receive path enable |
| mode_o | output | 2 | Current state code (see R11) |

## Verification
The hardest case to reach is a wake pin that is already asserted, or a short wake glitch, at the moment the block crosses into a low-power state. Entry only happens at the end of an enable-fall window, so its timing depends on where transmit data moves within that window. The stimulus therefore holds each pin for random durations drawn from a range around the acceptance window and the two hold times. It adds directed sequences that pull the local wake pin low before enable falls and that end wake pulses one sample short. A cycle model built from the requirements follows every edge, so each of these overlaps is checked where it lands.

// File: rtl/xcvr_mode_pkg.sv
// Shared types for the transceiver power-state sequencer.
// Assumes a two-bit state code that is visible at the block boundary.
package xcvr_mode_pkg;

    typedef enum logic [1:0] {
        MODE_FAILSAFE = 2'd0,
        MODE_NORMAL   = 2'd1,
        MODE_SILENT   = 2'd2,
        MODE_SLEEP    = 2'd3
    } xcvr_mode_e;

    typedef struct packed {
        logic reg_en;
        logic inh_en;
        logic wdg_en;
        logic tx_en;
        logic rx_en;
    } xcvr_ctrl_t;

    // Map a state to the enables it grants.
    function automatic xcvr_ctrl_t mode_to_ctrl(input xcvr_mode_e m);
        xcvr_ctrl_t c;
        c = '0;
        case (m)
            MODE_FAILSAFE: begin
                c.reg_en = 1'b1;
                c.inh_en = 1'b1;
                c.wdg_en = 1'b1;
            end
            MODE_NORMAL: begin
                c.reg_en = 1'b1;
                c.inh_en = 1'b1;
                c.wdg_en = 1'b1;
                c.tx_en  = 1'b1;
                c.rx_en  = 1'b1;
            end
            MODE_SILENT: begin
                c.reg_en = 1'b1;
            end
            default: c = '0;
        endcase
        return c;
    endfunction

endpackage

// File: rtl/xcvr_wake_filter.sv
// Wake qualifier: gives a one-cycle event once the pin has moved to its
// active level while armed and then stayed there for DB_CYC samples in a row,
// the first active sample included. A pin already active when arming
// begins must first return to its inactive level. Assumes pin_i is synchronous.
module xcvr_wake_filter #(
    parameter bit          ACT_HIGH = 1'b0,
    parameter int unsigned DB_CYC   = 3500
) (
    input  logic clk,
    input  logic rst_n,
    input  logic armed_i,
    input  logic pin_i,
    output logic event_o
);
    localparam int unsigned CW = $clog2(DB_CYC + 1);
    localparam logic [CW-1:0] LAST = CW'(DB_CYC - 1);

    logic          act;
    logic          act_q;
    logic          run_q;
    logic [CW-1:0] cnt_q;
    logic [CW-1:0] k;
    logic          start;
    logic          cont;

    // Qualify the pin level and find the first active sample.
    always_comb begin
        act     = (pin_i == ACT_HIGH);
        start   = armed_i & act & ~act_q;
        cont    = armed_i & act & run_q;
        k       = start ? '0 : cnt_q;
        event_o = (start | cont) && (k == LAST);
    end

    // Track the previous level and count the active run.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            act_q <= 1'b1;
            run_q <= 1'b0;
            cnt_q <= '0;
        end else begin
            act_q <= act;
            if ((start | cont) && !event_o) begin
                run_q <= 1'b1;
                cnt_q <= k + 1'b1;
            end else begin
                run_q <= 1'b0;
                cnt_q <= '0;
            end
        end
    end

    // R7, R8: a qualified wake is a single pulse and needs the pin still active.
    assert_wake_pulse_single_R7: assert property (@(posedge clk) disable iff (!rst_n)
        event_o |=> !event_o);
    assert_wake_level_held_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (event_o && DB_CYC > 1) |-> (act && act_q));

endmodule

// File: rtl/xcvr_lp_select.sv
// Low-power target selector: while the sequencer is active, a fall of enable
// opens a window of WIN_CYC samples. A low transmit-data sample inside the
// window requests deep power-down at once. A window that closes with data
// high requests quiet mode. A return of enable abandons the window.
module xcvr_lp_select #(
    parameter int unsigned WIN_CYC = 160
) (
    input  logic clk,
    input  logic rst_n,
    input  logic active_i,
    input  logic en_i,
    input  logic txd_i,
    output logic go_sleep_o,
    output logic go_silent_o
);
    localparam int unsigned CW = $clog2(WIN_CYC + 1);
    localparam logic [CW-1:0] LAST = CW'(WIN_CYC - 1);

    logic          en_q;
    logic [CW-1:0] cnt_q;
    logic          fall;
    logic          live;
    logic [CW-1:0] k;

    // Decode the window position and the two requests.
    always_comb begin
        fall        = en_q & ~en_i;
        k           = fall ? '0 : cnt_q;
        live        = active_i & ~en_i & (fall | (cnt_q != '0));
        go_sleep_o  = live & ~txd_i;
        go_silent_o = live & txd_i & (k == LAST);
    end

    // Remember enable and advance the window position.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            en_q  <= 1'b0;
            cnt_q <= '0;
        end else begin
            en_q <= en_i;
            if (live && !go_sleep_o && !go_silent_o) begin
                cnt_q <= k + 1'b1;
            end else begin
                cnt_q <= '0;
            end
        end
    end

    // R3: a quiet request after the first sample means data was high a cycle ago.
    assert_quiet_after_high_data_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (go_silent_o && cnt_q != '0) |-> $past(txd_i));

endmodule

// File: rtl/xcvr_mode_fsm.sv
// Four-state power sequencer. The reset indication has top priority in the
// active and quiet states, is ignored in deep power-down, and holds the
// block in protected start-up. Wake events always lead to protected start-up.
module xcvr_mode_fsm
    import xcvr_mode_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       en_i,
    input  logic       rst_ind_i,
    input  logic       go_sleep_i,
    input  logic       go_silent_i,
    input  logic       wake_any_i,
    output xcvr_mode_e mode_o
);
    xcvr_mode_e st_q;
    xcvr_mode_e st_d;

    // Pick the next state.
    always_comb begin
        st_d = st_q;
        case (st_q)
            MODE_FAILSAFE: if (!rst_ind_i && en_i) st_d = MODE_NORMAL;
            MODE_NORMAL: begin
                if (rst_ind_i)        st_d = MODE_FAILSAFE;
                else if (go_sleep_i)  st_d = MODE_SLEEP;
                else if (go_silent_i) st_d = MODE_SILENT;
            end
            MODE_SILENT: begin
                if (rst_ind_i || wake_any_i) st_d = MODE_FAILSAFE;
                else if (en_i)               st_d = MODE_NORMAL;
            end
            default: if (wake_any_i) st_d = MODE_FAILSAFE;
        endcase
    end

    // Hold the state register.
    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= MODE_FAILSAFE;
        else        st_q <= st_d;
    end

    assign mode_o = st_q;

    assert_reset_leaves_active_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == MODE_NORMAL && rst_ind_i) |=> (st_q == MODE_FAILSAFE));
    assert_active_held_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == MODE_NORMAL && en_i && !rst_ind_i) |=> (st_q == MODE_NORMAL));
    assert_quiet_needs_en_low_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == MODE_SILENT && $past(st_q) == MODE_NORMAL) |-> !$past(en_i));
    assert_deep_exit_by_wake_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == MODE_FAILSAFE && $past(st_q) == MODE_SLEEP) |-> $past(wake_any_i));
    assert_deep_ignores_reset_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == MODE_SLEEP && !wake_any_i) |=> (st_q == MODE_SLEEP));

endmodule

// File: rtl/xcvr_mode_ctrl.sv
// Top of the transceiver power-state sequencer. It joins the low-power
// selector, the two wake qualifiers (local pin active low, ignition pin
// active high) and the state machine, then decodes the enables.
// Assumes all pins are already synchronous to clk.
module xcvr_mode_ctrl
    import xcvr_mode_pkg::*;
#(
    parameter int unsigned SEL_WIN_CYC  = 160,
    parameter int unsigned LOCAL_DB_CYC = 3500,
    parameter int unsigned IGN_DB_CYC   = 8000
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       en_i,
    input  logic       txd_i,
    input  logic       wake_n_i,
    input  logic       ign_i,
    input  logic       rst_ind_i,
    output logic       reg_en_o,
    output logic       inh_en_o,
    output logic       wdg_en_o,
    output logic       tx_en_o,
    output logic       rx_en_o,
    output logic [1:0] mode_o
);
    localparam int unsigned NWAKE = 2;

    xcvr_mode_e       mode;
    xcvr_ctrl_t       ctrl;
    logic             armed;
    logic             active;
    logic             go_sleep;
    logic             go_silent;
    logic [NWAKE-1:0] wake_raw;
    logic [NWAKE-1:0] wake_evt;

    // Gate the filters and the selector by the current state.
    always_comb begin
        armed    = (mode == MODE_SILENT) || (mode == MODE_SLEEP);
        active   = (mode == MODE_NORMAL);
        wake_raw = {ign_i, wake_n_i};
    end

    for (genvar g = 0; g < NWAKE; g++) begin : g_wake
        localparam bit          ACT = (g == 1);
        localparam int unsigned DB  = (g == 0) ? LOCAL_DB_CYC : IGN_DB_CYC;
        xcvr_wake_filter #(
            .ACT_HIGH (ACT),
            .DB_CYC   (DB)
        ) u_filt (
            .clk     (clk),
            .rst_n   (rst_n),
            .armed_i (armed),
            .pin_i   (wake_raw[g]),
            .event_o (wake_evt[g])
        );
    end

    xcvr_lp_select #(
        .WIN_CYC (SEL_WIN_CYC)
    ) u_sel (
        .clk         (clk),
        .rst_n       (rst_n),
        .active_i    (active),
        .en_i        (en_i),
        .txd_i       (txd_i),
        .go_sleep_o  (go_sleep),
        .go_silent_o (go_silent)
    );

    xcvr_mode_fsm u_fsm (
        .clk         (clk),
        .rst_n       (rst_n),
        .en_i        (en_i),
        .rst_ind_i   (rst_ind_i),
        .go_sleep_i  (go_sleep),
        .go_silent_i (go_silent),
        .wake_any_i  (|wake_evt),
        .mode_o      (mode)
    );

    // Decode the enables from the state.
    always_comb begin
        ctrl     = mode_to_ctrl(mode);
        reg_en_o = ctrl.reg_en;
        inh_en_o = ctrl.inh_en;
        wdg_en_o = ctrl.wdg_en;
        tx_en_o  = ctrl.tx_en;
        rx_en_o  = ctrl.rx_en;
        mode_o   = mode;
    end

    // R1: the load switch is never on without the regulator.
    assert_switch_needs_supply_R1: assert property (@(posedge clk) disable iff (!rst_n)
        inh_en_o |-> reg_en_o);

endmodule

// File: tb/xcvr_mode_ctrl_bench.sv
module xcvr_mode_ctrl_bench;

    localparam int WIN = 8;
    localparam int LOC = 20;
    localparam int IGN = 40;
    localparam int FS = 0, NM = 1, SI = 2, SL = 3;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic en = 1'b0, txd = 1'b1, wake_n = 1'b1, ign = 1'b0, rst_ind = 1'b0;
    logic reg_en, inh_en, wdg_en, tx_en, rx_en;
    logic [1:0] mode;

    int n_chk = 0;
    int n_bad = 0;
    int cyc = 0;
    bit chk_on = 1'b0;

    always #10 clk = ~clk;

    xcvr_mode_ctrl #(
        .SEL_WIN_CYC  (WIN),
        .LOCAL_DB_CYC (LOC),
        .IGN_DB_CYC   (IGN)
    ) u_xcvr_mode_ctrl (
        .clk (clk), .rst_n (rst_n), .en_i (en), .txd_i (txd),
        .wake_n_i (wake_n), .ign_i (ign), .rst_ind_i (rst_ind),
        .reg_en_o (reg_en), .inh_en_o (inh_en), .wdg_en_o (wdg_en),
        .tx_en_o (tx_en), .rx_en_o (rx_en), .mode_o (mode)
    );

    // Reference model state, written from the requirements.
    int m_st = FS;
    bit m_enq = 1'b0;
    int m_win = 0;
    bit lw_prev = 1'b1, ig_prev = 1'b1;
    int lw_run = 0, ig_run = 0;

    function automatic logic [4:0] exp_ctrl(input int st);
        case (st)
            FS:      return 5'b11100;
            NM:      return 5'b11111;
            SI:      return 5'b10000;
            default: return 5'b00000;
        endcase
    endfunction

    function automatic string tag_of(input int st);
        case (st)
            FS:      return "R4";
            NM:      return "R1";
            SI:      return "R2";
            default: return "R3";
        endcase
    endfunction

    always @(posedge clk) begin
        bit armed, ev, sleep_req, quiet_req, fall;
        int pos, nx;
        cyc++;
        if (!rst_n) begin
            m_st = FS; m_enq = 1'b0; m_win = 0;
            lw_prev = 1'b1; ig_prev = 1'b1; lw_run = 0; ig_run = 0;
        end else begin
            armed = (m_st == SI) || (m_st == SL);
            ev = 1'b0;
            if (armed && !wake_n && (lw_run > 0 || !lw_prev)) begin
                lw_run++;
                if (lw_run == LOC) begin ev = 1'b1; lw_run = 0; end
            end else lw_run = 0;
            lw_prev = !wake_n;
            if (armed && ign && (ig_run > 0 || !ig_prev)) begin
                ig_run++;
                if (ig_run == IGN) begin ev = 1'b1; ig_run = 0; end
            end else ig_run = 0;
            ig_prev = ign;
            fall = m_enq && !en;
            sleep_req = 1'b0; quiet_req = 1'b0;
            if (m_st == NM && !en && (fall || m_win > 0)) begin
                pos = fall ? 0 : m_win;
                if (!txd) sleep_req = 1'b1;
                else if (pos == WIN - 1) quiet_req = 1'b1;
                m_win = (sleep_req || quiet_req) ? 0 : pos + 1;
            end else m_win = 0;
            m_enq = en;
            nx = m_st;
            case (m_st)
                FS: if (!rst_ind && en) nx = NM;
                NM: if (rst_ind) nx = FS; else if (sleep_req) nx = SL; else if (quiet_req) nx = SI;
                SI: if (rst_ind || ev) nx = FS; else if (en) nx = NM;
                default: if (ev) nx = FS;
            endcase
            m_st = nx;
        end
    end

    // Compare every cycle against the model, away from the active edge.
    always @(negedge clk) begin
        if (chk_on) begin
            n_chk++;
            if (int'(mode) != m_st || {reg_en, inh_en, wdg_en, tx_en, rx_en} != exp_ctrl(m_st)) begin
                n_bad++;
                $display("FAIL %s model: mode=%0d en=%b expected mode=%0d en=%b", tag_of(m_st),
                         mode, {reg_en, inh_en, wdg_en, tx_en, rx_en}, m_st, exp_ctrl(m_st));
            end
        end
    end

    always @(posedge clk) begin
        if (cyc > 150000) begin
            n_bad++;
            $display("FAIL watchdog: run still going at cycle %0d, expected end earlier", cyc);
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end

    task automatic step(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic expect_mode(input string tag, input int exp);
        n_chk++;
        if (int'(mode) != exp) begin
            n_bad++;
            $display("FAIL %s directed: mode=%0d expected %0d", tag, mode, exp);
        end
    endtask

    initial begin
        void'($urandom(32'd20240611));
        step(3);
        rst_n = 1'b1;
        step(1);
        chk_on = 1'b1;
        // R11: reset state and enables
        expect_mode("R11", FS);
        n_chk++;
        if ({reg_en, inh_en, wdg_en, tx_en, rx_en} != 5'b11100) begin
            n_bad++;
            $display("FAIL R11 enables=%b expected 11100", {reg_en, inh_en, wdg_en, tx_en, rx_en});
        end
        en = 1'b1; step(1); expect_mode("R1", NM);
        // R2: full window with data high
        en = 1'b0; txd = 1'b1; step(WIN - 1); expect_mode("R2", NM);
        step(1); expect_mode("R2", SI);
        // R9 short pulse, then R7 full wake
        wake_n = 1'b0; step(LOC - 1); wake_n = 1'b1; step(2); expect_mode("R9", SI);
        wake_n = 1'b0; step(LOC - 1); expect_mode("R7", SI);
        step(1); expect_mode("R7", FS);
        wake_n = 1'b1;
        // R3: data drops late in the window
        en = 1'b1; step(1); expect_mode("R1", NM);
        en = 1'b0; txd = 1'b1; step(WIN - 2); txd = 1'b0; step(1); expect_mode("R3", SL);
        // R5 and R10 in deep power-down
        rst_ind = 1'b1; step(3); expect_mode("R5", SL);
        en = 1'b1; step(2); expect_mode("R10", SL);
        rst_ind = 1'b0; en = 1'b0;
        // R8 ignition
        ign = 1'b1; step(IGN - 1); expect_mode("R8", SL);
        step(1); expect_mode("R8", FS);
        ign = 1'b0;
        // R9 wake held across entry, simultaneous fall selects R3
        en = 1'b1; txd = 1'b1; step(1); expect_mode("R1", NM);
        wake_n = 1'b0; step(2);
        en = 1'b0; txd = 1'b0; step(1); expect_mode("R3", SL);
        step(LOC + 5); expect_mode("R9", SL);
        wake_n = 1'b1; step(1); wake_n = 1'b0; step(LOC); expect_mode("R7", FS);
        wake_n = 1'b1;
        // R6 abandoned window
        en = 1'b1; txd = 1'b1; step(1); expect_mode("R1", NM);
        en = 1'b0; step(3); en = 1'b1; step(WIN + 2); expect_mode("R6", NM);
        // R4 reset indication from active and its release
        rst_ind = 1'b1; step(1); expect_mode("R4", FS);
        step(2); expect_mode("R4", FS);
        rst_ind = 1'b0; step(1); expect_mode("R4", NM);
        // R10 quiet back to active, then R4 from quiet
        en = 1'b0; step(WIN); expect_mode("R2", SI);
        en = 1'b1; step(1); expect_mode("R10", NM);
        en = 1'b0; step(WIN); expect_mode("R2", SI);
        rst_ind = 1'b1; step(1); expect_mode("R4", FS);
        rst_ind = 1'b0;
        // Random phase, checked every cycle by the model
        for (int i = 0; i < 500; i++) begin
            int pick;
            pick = int'($urandom_range(0, 9));
            case (pick)
                0, 1:    en = ~en;
                2, 3:    txd = ~txd;
                4, 5:    wake_n = ~wake_n;
                6, 7:    ign = ~ign;
                8:       rst_ind = ($urandom_range(0, 3) == 0);
                default: begin en = ~en; txd = $urandom_range(0, 1) != 0; end
            endcase
            step(int'($urandom_range(1, 50)));
        end
        rst_ind = 1'b0;
        step(2);
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

endmodule